// File: doc/BRIEF.md
# Temperature Conversion and Compensation Sequencer

This block decides when a temperature sensor is asked for a new reading and what is done with the result. It keeps a fixed schedule of one conversion for every 64 ticks of a 1 Hz time base, and it starts a conversion straight out of reset. Software may force an extra conversion by writing the convert bit. That request runs alongside the fixed schedule and never moves it.

Each result is a 10-bit two's-complement temperature with 0.25 °C steps. The block presents it as an integer byte and a fraction byte. The result is also turned into a capacitance code for the crystal load array. A placeholder lookup maps the temperature to a base code. A signed aging offset is added to that base, and the sum is clamped to the code range.

Progress is reported on two status outputs. The convert bit follows a forced conversion from the write to its end. The busy bit follows scheduled conversions at once. For a forced conversion, busy stays low for a programmable number of clock cycles and rises only if the conversion is still running after that.

Top module: `temp_comp_seq`

## Requirements
- R1: During and after reset, busy=0, conv=0, both temperature bytes are 0 and cap_code=128. A scheduled conversion is launched on the first clock edge after reset is released, so busy=1 one cycle after release.
- R2: A scheduled conversion is requested on every 64th tick_1hz pulse, counting from reset. A request that arrives while a conversion is running waits until the block is idle.
- R3: A conv_wr pulse starts a forced conversion only when the block is idle and no scheduled request is pending. Otherwise it is ignored, and conv keeps its value; in particular conv stays 0 during a scheduled conversion.
- R4: Forced conversions do not restart or shift the 64-tick schedule.
- R5: conv is 1 from the cycle after an accepted conv_wr until the conversion ends. In the cycle after sens_done, both conv and busy are 0.
- R6: A scheduled conversion raises busy in the same cycle as sens_start. A forced conversion leaves busy at 0 for MASK_CYCLES clock edges after it is accepted, then sets busy to 1 if the conversion has not yet ended.
- R7: Every conversion produces exactly one sens_start pulse, one cycle long.
- R8: The temperature bytes are laid out as follows. temp_msb holds result bits 9:2 (the signed integer). temp_lsb bits 7:6 hold result bits 1:0 (the quarter degrees), and temp_lsb bits 5:0 read 0. Example: result 0001100101 reads 0x19 and 0x40 (+25.25 °C).
- R9: cap_code is the integer byte plus 128 plus the signed aging value, clamped to the range 0..255. It is updated when a forced conversion ends, or when a scheduled result differs from the stored temperature. Otherwise it holds its value.
- R10: The temperature bytes take the sensor result in the cycle after every sens_done, whether the conversion was scheduled or forced. They change at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| conv_wr | input | 1 | One-cycle write of 1 to the convert bit |
| aging | input | 8 | Signed aging offset |
| sens_done | input | 1 | Sensor result valid, one cycle |
| sens_temp | input | 10 | Sensor result, two's complement, 0.25 °C steps |
| sens_start | output | 1 | One-cycle conversion start to the sensor |
| busy | output | 1 | Busy status bit |
| conv | output | 1 | Convert status bit |
| temp_msb | output | 8 | Integer temperature byte |
| temp_lsb | output | 8 | Fraction byte, bits 7:6 |
| cap_code | output | 8 | Capacitance array code |

## Verification
The assertions assume a well-behaved sensor. It raises sens_done for exactly one cycle, and only after a sens_start that has not yet been answered. They also assume that tick_1hz and conv_wr are single-cycle pulses. The bench sensor model drives sens_done once per start, at least one cycle later and on the falling clock edge. All other bench stimulus is applied as one-cycle pulses on the falling edge. The forced-conversion requests aimed at running conversions are issued only after the start pulse has been seen, so these rules are never broken.

// File: rtl/temp_comp_seq_pkg.sv
package temp_comp_seq_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/tcs_schedule.sv
module tcs_schedule #(
    parameter int PERIOD_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    output logic pend
);
    localparam int CW = $clog2(PERIOD_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } sched_t;

    sched_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (take) s_d.pend = 1'b0;
        if (tick) begin
            if (s_q.cnt == CW'(PERIOD_TICKS - 1)) begin
                s_d.cnt  = '0;
                s_d.pend = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.pend <= 1'b1;   // launch a conversion right after reset
        end else begin
            s_q <= s_d;
        end
    end

    assign pend = s_q.pend;
endmodule

// File: rtl/tcs_cap_calc.sv
module tcs_cap_calc #(
    parameter int TEMP_W = 10,
    parameter int FRAC_W = 2,
    parameter int AGE_W  = 8,
    parameter int CAP_W  = 8
) (
    input  logic [TEMP_W-1:0] temp,
    input  logic [AGE_W-1:0]  age,
    output logic [CAP_W-1:0]  code
);
    localparam int INT_W = TEMP_W - FRAC_W;
    localparam int SW    = CAP_W + 3;
    localparam int MID   = 2 ** (CAP_W - 1);
    localparam int TOP   = 2 ** CAP_W - 1;

    logic signed [SW-1:0] base_s, age_s, sum_s;

    always_comb begin
        base_s = SW'(MID) + SW'($signed(temp[TEMP_W-1:FRAC_W]));
        age_s  = SW'($signed(age));
        sum_s  = base_s + age_s;
        if (sum_s < 0)
            code = '0;
        else if (sum_s > SW'(TOP))
            code = CAP_W'(TOP);
        else
            code = sum_s[CAP_W-1:0];
    end

    logic unused_w;
    assign unused_w = ^INT_W;
endmodule

// File: rtl/temp_comp_seq.sv
module temp_comp_seq
    import temp_comp_seq_pkg::*;
#(
    parameter int PERIOD_TICKS = 64,
    parameter int MASK_CYCLES  = 500000,
    parameter int TEMP_W       = 10,
    parameter int FRAC_W       = 2,
    parameter int AGE_W        = 8,
    parameter int CAP_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              conv_wr,
    input  logic [AGE_W-1:0]  aging,
    input  logic              sens_done,
    input  logic [TEMP_W-1:0] sens_temp,
    output logic              sens_start,
    output logic              busy,
    output logic              conv,
    output logic [7:0]        temp_msb,
    output logic [7:0]        temp_lsb,
    output logic [CAP_W-1:0]  cap_code
);
    localparam int MW      = $clog2(MASK_CYCLES + 1);
    localparam int INT_W   = TEMP_W - FRAC_W;
    localparam int CAP_RST = 2 ** (CAP_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic              start;
        logic              busy;
        logic              conv;
        logic              user;
        logic [MW-1:0]     mask_cnt;
        logic [TEMP_W-1:0] temp;
        logic [CAP_W-1:0]  cap;
    } seq_t;

    seq_t r_d, r_q;
    logic pend, take;
    logic [CAP_W-1:0] cap_new;

    tcs_schedule #(.PERIOD_TICKS(PERIOD_TICKS)) u_sched (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_1hz),
        .take (take),
        .pend (pend)
    );

    tcs_cap_calc #(
        .TEMP_W(TEMP_W), .FRAC_W(FRAC_W), .AGE_W(AGE_W), .CAP_W(CAP_W)
    ) u_cap (
        .temp(sens_temp),
        .age (aging),
        .code(cap_new)
    );

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        take      = 1'b0;
        case (r_q.phase)
            PH_IDLE: begin
                if (pend) begin
                    // scheduled work wins over a same-cycle user write
                    take      = 1'b1;
                    r_d.phase = PH_RUN;
                    r_d.start = 1'b1;
                    r_d.busy  = 1'b1;
                    r_d.user  = 1'b0;
                end else if (conv_wr) begin
                    r_d.phase    = PH_RUN;
                    r_d.start    = 1'b1;
                    r_d.conv     = 1'b1;
                    r_d.user     = 1'b1;
                    r_d.mask_cnt = '0;
                end
            end
            default: begin
                if (sens_done) begin
                    r_d.phase = PH_IDLE;
                    r_d.busy  = 1'b0;
                    r_d.conv  = 1'b0;
                    r_d.user  = 1'b0;
                    r_d.temp  = sens_temp;
                    if (r_q.user || (sens_temp != r_q.temp))
                        r_d.cap = cap_new;
                end else if (r_q.user && !r_q.busy) begin
                    if (r_q.mask_cnt == MW'(MASK_CYCLES - 1))
                        r_d.busy = 1'b1;
                    else
                        r_d.mask_cnt = r_q.mask_cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.phase    <= PH_IDLE;
            r_q.start    <= 1'b0;
            r_q.busy     <= 1'b0;
            r_q.conv     <= 1'b0;
            r_q.user     <= 1'b0;
            r_q.mask_cnt <= '0;
            r_q.temp     <= '0;
            r_q.cap      <= CAP_W'(CAP_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign sens_start = r_q.start;
    assign busy       = r_q.busy;
    assign conv       = r_q.conv;
    assign temp_msb   = 8'(r_q.temp[TEMP_W-1:FRAC_W]);
    assign temp_lsb   = {r_q.temp[FRAC_W-1:0], {(8 - FRAC_W){1'b0}}};
    assign cap_code   = r_q.cap;

    logic unused_w;
    assign unused_w = ^INT_W;
endmodule

// File: rtl/temp_comp_seq_chk.sv
module temp_comp_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       conv_wr,
    input logic       sens_done,
    input logic       sens_start,
    input logic       busy,
    input logic       conv,
    input logic [7:0] temp_msb,
    input logic [7:0] temp_lsb
);
    // R7: the start request lasts one cycle
    assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sens_start |=> !sens_start);

    // R6: a scheduled start comes with busy already high
    assert_sched_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sens_start && !conv) |-> busy);

    // R6: a forced start leaves busy low at first
    assert_user_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sens_start && conv) |-> !busy);

    // R5: convert and busy end together
    assert_conv_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv) |-> !busy);

    // R5: busy never drops while a forced conversion is still marked
    assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !conv);

    // R3: a write during a scheduled conversion leaves conv at 0
    assert_ignore_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_wr && busy && !conv) |=> !conv);

    // R8: unused fraction bits read zero
    assert_lsb_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        temp_lsb[5:0] == 6'b0);

    // R10: temperature moves only after a completion
    assert_temp_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((temp_msb != $past(temp_msb)) || (temp_lsb != $past(temp_lsb)))
            |-> $past(sens_done));
endmodule

bind temp_comp_seq temp_comp_seq_chk u_chk (.*);

// File: tb/sim_temp_comp_seq.sv
module sim_temp_comp_seq;
    localparam int MASK = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1hz = 1'b0, conv_wr = 1'b0, sens_done = 1'b0;
    logic [7:0] aging = 8'd0;
    logic [9:0] sens_temp = '0;
    logic sens_start, busy, conv;
    logic [7:0] temp_msb, temp_lsb, cap_code;

    int n_chk = 0, n_fail = 0, n_starts = 0, lat = 8;
    logic [9:0] next_temp = 10'd101;

    always #2 clk = ~clk;   // 250 MHz

    temp_comp_seq #(.MASK_CYCLES(MASK)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .conv_wr(conv_wr),
        .aging(aging), .sens_done(sens_done), .sens_temp(sens_temp),
        .sens_start(sens_start), .busy(busy), .conv(conv),
        .temp_msb(temp_msb), .temp_lsb(temp_lsb), .cap_code(cap_code)
    );

    // sensor model
    initial forever begin
        @(negedge clk);
        if (sens_start) begin
            n_starts++;
            repeat (lat - 1) @(negedge clk);
            sens_temp = next_temp;
            sens_done = 1'b1;
            @(negedge clk);
            sens_done = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_cap(input logic [9:0] t, input logic [7:0] a);
        int s;
        s = 128 + int'($signed(t[9:2])) + int'($signed(a));
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (busy || conv) @(negedge clk);
    endtask

    task automatic pulse_wr();
        @(negedge clk); conv_wr = 1'b1;
        @(negedge clk); conv_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 conv", conv, 0);
        check("R1 temp", {temp_msb, temp_lsb}, 0);
        check("R1 cap", cap_code, 128);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 launch busy", busy, 1);
        check("R6 sched start", sens_start, 1);
        wait_idle();
        check("R8 msb", temp_msb, 8'h19);
        check("R8 lsb", temp_lsb, 8'h40);
        check("R9 cap", cap_code, exp_cap(10'd101, 8'd0));
        check("R7 starts", n_starts, 1);
    endtask

    task automatic t_user_mask();
        aging = 8'd5; next_temp = 10'd982; lat = 40;
        pulse_wr();
        check("R5 conv set", conv, 1);
        repeat (5) @(negedge clk);
        check("R6 busy masked", busy, 0);
        repeat (25) @(negedge clk);
        check("R6 busy late", busy, 1);
        check("R5 conv held", conv, 1);
        wait_idle();
        check("R5 conv clr", conv, 0);
        check("R5 busy clr", busy, 0);
        check("R10 msb", temp_msb, 8'hF5);
        check("R8 lsb frac", temp_lsb, 8'h80);
        check("R9 cap user", cap_code, exp_cap(10'd982, 8'd5));
    endtask

    task automatic t_sat();
        lat = 4;
        aging = 8'd127; next_temp = 10'd508;
        pulse_wr(); wait_idle();
        check("R9 sat high", cap_code, 255);
        aging = 8'h80; next_temp = 10'd512;
        pulse_wr(); wait_idle();
        check("R9 sat low", cap_code, 0);
        check("R10 msb neg", temp_msb, 8'h80);
    endtask

    task automatic t_schedule();
        int s0;
        lat = 10;
        ticks(10);
        aging = 8'd20;
        pulse_wr(); wait_idle();
        check("R9 user same temp", cap_code, 20);
        s0 = n_starts;
        ticks(50);   // 60 ticks since reset so far, plus the bring-up
        ticks(3);    // 63
        check("R4 no early start", n_starts, s0);
        aging = 8'd50;
        ticks(1);    // 64th
        @(negedge clk);
        check("R2 sched busy", busy, 1);
        check("R2 sched conv", conv, 0);
        pulse_wr();
        check("R3 ignored wr", conv, 0);
        wait_idle();
        check("R3 one start", n_starts, s0 + 1);
        check("R9 unchanged hold", cap_code, 20);
        next_temp = 10'd0;
        ticks(63);
        check("R2 period", n_starts, s0 + 1);
        ticks(1);
        wait_idle();
        check("R2 second", n_starts, s0 + 2);
        check("R9 changed", cap_code, exp_cap(10'd0, 8'd50));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_user_mask();
        t_sat();
        t_schedule();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule